// File: doc/BRIEF.md
# Trip Request Monitor

The block watches three active-low emergency trip pins and turns each into a sticky request flag. Every pin has its own two-bit acceptance mode. Mode 0 takes any falling edge of the pin. The other three modes accept a request only once the pin has read low on sixteen samples in a row. The samples are taken on one of three prescaled strobes. Each pin input passes through a two-stage synchroniser before any of this logic sees it.

The three flags are ORed together. The result is gated by an enable bit to form the interrupt request. The modes and the enable live in one control word, which is written and read through a plain register port. Software drops a flag by pulsing the matching clear bit.

Top module: `trip_request_monitor`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x0000, `flags` reads 000 and `irq` is 0.
- R2: Control word layout: bit 8 is the interrupt enable, bits 1:0 hold the mode of pin 0, bits 3:2 the mode of pin 1 and bits 5:4 the mode of pin 2. All other bits, the reserved bits 7:6 among them, read 0 and ignore writes. When `ctl_we` is high, the word is loaded at the clock edge, and `ctl_rdata` shows the stored word with no extra delay. Writing 0xFFFF therefore reads back 0x013F.
- R3: In mode 00, a falling edge on a pin sets that pin's flag. If the pin goes low just before rising edge k, the flag is 1 after edge k+2 and still 0 after edge k+1.
- R4: In modes 01, 10 and 11, the flag is set when 16 consecutive samples of the synchronised pin all read low. A single high sample restarts the count. Two low runs of 100 cycles split by a 20-cycle high stretch do not set the flag in mode 01.
- R5: In mode 01 the pin is sampled once every 8 clocks, in mode 10 once every 16 clocks and in mode 11 once every 128 clocks. A low pin sets the flag no later than 16×N+8 cycles after it falls, and not within 15×N cycles, where N is the sampling interval.
- R6: A set flag stays at 1 until its bit of `flag_clr` is 1 at a clock edge. It reads 0 after that edge.
- R7: If a new request is accepted on the same edge as a clear of that pin, the flag stays 1.
- R8: `irq` equals the enable bit ANDed with the OR of the three flags, with no register delay.
- R9: Each pin follows only its own mode field, and a request on one pin sets only that pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_n | input | 3 | Active-low trip request pins (asynchronous) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read data |
| flag_clr | input | 3 | Per-pin flag clear, 1 clears |
| flags | output | 3 | Sticky per-pin request flags |
| irq | output | 1 | Interrupt request |

## Verification
Edge mode is driven with a clean falling edge and sampled one edge early and on time, which fixes the synchroniser latency. Each filter mode gets a held-low pin and is checked against a lower and an upper window. Because the windows of neighbouring rates do not overlap, a wrong divider shows up as an early or a missing flag. A low-high-low pattern shows that a high sample restarts the run rather than pausing it. A second falling edge that lands on a clear separates "request wins" from "clear wins". A mixed mode word with an edge on one pin confirms that each pin keeps to its own field.

// File: rtl/trip_pkg.sv
package trip_pkg;
  typedef enum logic [1:0] {
    TRIP_EDGE   = 2'b00,
    TRIP_SLOW_A = 2'b01,
    TRIP_SLOW_B = 2'b10,
    TRIP_SLOW_C = 2'b11
  } trip_mode_e;

  localparam int unsigned TRIP_PINS    = 3;
  localparam int unsigned TRIP_RUN     = 16;
  localparam int unsigned TRIP_DIV_A   = 8;
  localparam int unsigned TRIP_DIV_B   = 16;
  localparam int unsigned TRIP_DIV_C   = 128;
  localparam int unsigned TRIP_DATA_W  = 16;
  localparam int unsigned TRIP_IE_BIT  = 8;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q, meta_d;
  logic sync_q, sync_d;

  always_comb begin
    meta_d = d_async;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/trip_prescaler.sv
module trip_prescaler #(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 16,
  parameter int unsigned DIV_C = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_a,
  output logic tick_b,
  output logic tick_c
);
  localparam int unsigned W = (DIV_C > 2) ? $clog2(DIV_C) : 1;
  localparam logic [W-1:0] MASK_A = W'(DIV_A - 1);
  localparam logic [W-1:0] MASK_B = W'(DIV_B - 1);
  localparam logic [W-1:0] MASK_C = W'(DIV_C - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q + W'(1);
    tick_a = (cnt_q & MASK_A) == MASK_A;
    tick_b = (cnt_q & MASK_B) == MASK_B;
    tick_c = (cnt_q & MASK_C) == MASK_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the slowest strobe coincides with the faster ones
  p_nested_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_c |-> (tick_b && tick_a));
  // R5: strobes are one clock wide
  p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |=> !tick_a);
endmodule

// File: rtl/trip_pin_unit.sv
module trip_pin_unit
  import trip_pkg::*;
#(
  parameter int unsigned RUN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  trip_mode_e mode,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       tick_c,
  input  logic       clr,
  output logic       flag
);
  localparam int unsigned CW = (RUN > 2) ? $clog2(RUN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic          pin_s;
  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          fall, tick_sel, sample, accept;

  trip_sync #(.IDLE(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_n),
    .q_sync  (pin_s)
  );

  always_comb begin
    fall = prev_q & ~pin_s;
    unique case (mode)
      TRIP_SLOW_A: tick_sel = tick_a;
      TRIP_SLOW_B: tick_sel = tick_b;
      TRIP_SLOW_C: tick_sel = tick_c;
      default:     tick_sel = 1'b0;
    endcase
    sample = (mode != TRIP_EDGE) && tick_sel;
    prev_d = pin_s;

    cnt_d  = cnt_q;
    accept = 1'b0;
    if (mode == TRIP_EDGE) begin
      cnt_d  = '0;
      accept = fall;
    end else if (sample) begin
      if (pin_s) begin
        cnt_d = '0;
      end else begin
        cnt_d  = cnt_q + CW'(1);
        accept = (cnt_q == LAST);
      end
    end

    if (accept)   flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R6: a flag holds while no clear is applied
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R7: a clear without a coincident request empties the flag
  p_clear_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> !flag_q);
  // R4: a filtered acceptance happens only on a low sample
  p_filter_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode != TRIP_EDGE) |-> !pin_s);
  // R4: a high sample restarts the run
  p_high_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && pin_s) |=> (cnt_q == '0));
endmodule

// File: rtl/trip_request_monitor.sv
module trip_request_monitor
  import trip_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TRIP_PINS-1:0]   trip_n,
  input  logic                   ctl_we,
  input  logic [TRIP_DATA_W-1:0] ctl_wdata,
  output logic [TRIP_DATA_W-1:0] ctl_rdata,
  input  logic [TRIP_PINS-1:0]   flag_clr,
  output logic [TRIP_PINS-1:0]   flags,
  output logic                   irq
);
  localparam int unsigned MODE_BITS = 2 * TRIP_PINS;

  logic [TRIP_PINS-1:0][1:0] mode_q, mode_d;
  logic                      ie_q, ie_d;
  logic                      tick_a, tick_b, tick_c;

  trip_prescaler #(
    .DIV_A (TRIP_DIV_A),
    .DIV_B (TRIP_DIV_B),
    .DIV_C (TRIP_DIV_C)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_a (tick_a),
    .tick_b (tick_b),
    .tick_c (tick_c)
  );

  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    if (ctl_we) begin
      ie_d = ctl_wdata[TRIP_IE_BIT];
      for (int i = 0; i < TRIP_PINS; i++) mode_d[i] = ctl_wdata[2*i +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ie_q   <= ie_d;
    end
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[TRIP_IE_BIT] = ie_q;
    ctl_rdata[MODE_BITS-1:0] = mode_q;
  end

  for (genvar g = 0; g < TRIP_PINS; g++) begin : g_pin
    trip_pin_unit #(.RUN(TRIP_RUN)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (trip_n[g]),
      .mode   (trip_mode_e'(mode_q[g])),
      .tick_a (tick_a),
      .tick_b (tick_b),
      .tick_c (tick_c),
      .clr    (flag_clr[g]),
      .flag   (flags[g])
    );
  end

  assign irq = ie_q & (|flags);

  // R8: no interrupt without a pending flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
  // R8: no interrupt while disabled
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[TRIP_IE_BIT] |-> !irq);
  // R2: a write lands on the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[MODE_BITS-1:0] == $past(ctl_wdata[MODE_BITS-1:0])));
endmodule

// File: tb/tb_trip_request_monitor.sv
module tb_trip_request_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  trip_n;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic [15:0] ctl_rdata;
  logic [2:0]  flag_clr;
  logic [2:0]  flags;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trip_request_monitor dut (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .flag_clr(flag_clr),
    .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [15:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    step(1);
    ctl_we = 1'b0;
  endtask

  task automatic clear_all();
    flag_clr = 3'b111; step(1); flag_clr = 3'b000;
  endtask

  task automatic t_reset();
    chk("R1 rdata", ctl_rdata, 16'h0000);
    chk("R1 flags", {13'd0, flags}, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_register();
    write_ctl(16'hFFFF);
    chk("R2 all ones readback", ctl_rdata, 16'h013F);
    write_ctl(16'h0024);
    chk("R2 mixed readback", ctl_rdata, 16'h0024);
    write_ctl(16'h0000);
    chk("R2 zero readback", ctl_rdata, 16'h0000);
  endtask

  task automatic t_edge();
    trip_n[0] = 1'b0;
    step(2);
    chk("R3 not yet after k+1", {13'd0, flags}, 16'h0);
    step(1);
    chk("R3 set after k+2", {13'd0, flags}, 16'h1);
    trip_n[0] = 1'b1; step(4);
    chk("R6 sticky after pin rises", {13'd0, flags}, 16'h1);
    clear_all();
    chk("R6 cleared", {13'd0, flags}, 16'h0);
  endtask

  task automatic t_clear_priority();
    trip_n[1] = 1'b0; step(4); trip_n[1] = 1'b1; step(4);
    chk("R7 first request", {13'd0, flags}, 16'h2);
    trip_n[1] = 1'b0;
    step(2);
    flag_clr = 3'b010;
    step(1);
    flag_clr = 3'b000;
    chk("R7 request beats clear", {13'd0, flags}, 16'h2);
    trip_n[1] = 1'b1; step(4);
    clear_all();
    chk("R7 plain clear", {13'd0, flags}, 16'h0);
  endtask

  task automatic t_filter(input logic [1:0] code, input int no_len, input int yes_len);
    write_ctl({10'd0, code, 4'd0});
    trip_n[2] = 1'b0;
    step(no_len);
    chk($sformatf("R5 mode %0d too early", code), {13'd0, flags}, 16'h0);
    step(yes_len - no_len);
    chk($sformatf("R5 mode %0d accepted", code), {13'd0, flags}, 16'h4);
    trip_n[2] = 1'b1; step(4);
    write_ctl(16'h0000);
    clear_all();
  endtask

  task automatic t_glitch();
    write_ctl(16'h0001);
    trip_n[0] = 1'b0; step(100);
    trip_n[0] = 1'b1; step(20);
    trip_n[0] = 1'b0; step(100);
    chk("R4 high sample restarts run", {13'd0, flags}, 16'h0);
    step(40);
    chk("R4 full run accepted", {13'd0, flags}, 16'h1);
    trip_n[0] = 1'b1; step(4);
    write_ctl(16'h0000);
    clear_all();
  endtask

  task automatic t_independent();
    write_ctl(16'h0024);
    trip_n[0] = 1'b0; step(4);
    chk("R9 only pin0 flagged", {13'd0, flags}, 16'h1);
    trip_n[1] = 1'b0; step(4);
    chk("R9 pin1 filter not met by edge", {13'd0, flags}, 16'h1);
    trip_n = 3'b111; step(4);
    write_ctl(16'h0000);
    clear_all();
  endtask

  task automatic t_irq();
    trip_n[2] = 1'b0; step(4); trip_n[2] = 1'b1; step(2);
    chk("R8 disabled irq low", {15'd0, irq}, 16'h0);
    write_ctl(16'h0100);
    chk("R8 enabled irq high", {15'd0, irq}, 16'h1);
    clear_all();
    chk("R8 irq drops with flag", {15'd0, irq}, 16'h0);
    write_ctl(16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; trip_n = 3'b111; ctl_we = 1'b0; ctl_wdata = '0; flag_clr = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_register();
    t_edge();
    t_clear_priority();
    t_filter(2'b01, 120, 136);
    t_filter(2'b10, 240, 264);
    t_filter(2'b11, 1920, 2056);
    t_glitch();
    t_independent();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule